// File: doc/BRIEF.md
# Two-Phase Page DMA Sequencer

The sequencer moves one flash page of 512 bytes between a byte-wide flash data port and system memory. Every transfer passes through an on-board page buffer and is split into two phases, each with its own completion interrupt. The device phase moves bytes between the flash port and the buffer. The memory phase moves 32-bit words between the buffer and memory, using a request/acknowledge interface.

The host sets the transfer direction with a read bit. For a read, it runs the device phase first (flash to buffer) and then the memory phase (buffer to memory). For a write, it runs the memory phase first (memory to buffer) and then the device phase (buffer to flash). The host loads the memory address, raises the bit of the first phase, waits for its interrupt, and then raises the bit of the second phase. A settings write whose two phase bits are both clear halts all activity. Errors are reported through a third status bit.

The register file has four word registers, selected by `reg_addr`:

| Offset | Register | Contents |
|---|---|---|
| 0 | settings | bit 0 read direction, bit 1 device phase, bit 2 memory phase |
| 1 | memory address | base byte address of the page |
| 2 | interrupt enable | same bit positions as the status register |
| 3 | status | bit 0 device phase done, bit 1 memory phase done, bit 2 error |

Top module: `pgdma_seq`

## Requirements
- R1: While reset is held, and right after it, `irq`, `mem_req`, `dev_in_ready` and `dev_out_valid` are low. Status (offset 3) and the memory address (offset 1) read back as zero.
- R2: A write to offset 1 stores a memory address, and a read of offset 1 returns the value written.
- R3: A device phase in the read direction accepts exactly 512 bytes on `dev_in`. After the last byte, `dev_in_ready` falls and status bit 0 is set.
- R4: A memory phase in the read direction issues 128 word writes, with word i at base + 4·i. Byte 4·i+j of the buffer sits in bits 8·j+7:8·j of that word. After the last write, status bit 1 is set.
- R5: A memory phase in the write direction reads 128 words from base + 4·i into the buffer. The following device phase in the write direction sends the 512 buffer bytes on `dev_out`, low byte of each word first, and then sets status bit 0.
- R6: A phase starts only when a settings write takes its phase bit from 0 to 1 (bit 1 device, bit 2 memory). Writing a phase bit that is already set starts nothing.
- R7: A settings write with bits 1 and 2 both clear stops a running phase from the next cycle on, and no done bit is set.
- R8: A settings write with bits 1 and 2 both set starts no phase and sets status bit 2.
- R9: Starting a phase while another is busy sets status bit 2. The running phase goes on to completion, and at most one phase is active at a time.
- R10: An acknowledge that carries `mem_err` sets status bit 2 and ends the memory phase (`mem_req` falls) without setting status bit 1.
- R11: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If the block raises a bit in the same cycle the host clears it, the bit stays set.
- R12: `irq` is high exactly when some status bit is set together with its enable bit at offset 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at `reg_addr` |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory word access request |
| mem_we | output | 1 | Access is a write to memory |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | WORD_W | Word written to memory |
| mem_ack | input | 1 | Memory completes the access this cycle |
| mem_rdata | input | WORD_W | Word read from memory |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| dev_in_valid | input | 1 | Flash byte available |
| dev_in_data | input | 8 | Flash byte |
| dev_in_ready | output | 1 | Sequencer takes a flash byte |
| dev_out_valid | output | 1 | Byte for the flash is valid |
| dev_out_data | output | 8 | Byte for the flash |
| dev_out_ready | input | 1 | Flash takes the byte |

## Verification
The interesting collision is between the sequencer raising the memory-done status bit on the final word acknowledge and the host's write-one-to-clear of that same bit. The bench provokes it by watching `mem_addr` until the last word's address appears with the request up. It then drives the clearing write in that same cycle, so that both land on one clock edge. A readback of the status register afterwards must still show the bit set. A second collision, a phase start arriving while another phase is busy, is judged by an error bit that appears at once while the busy phase still ends with its own done bit.

// File: rtl/pgdma_pkg.sv
package pgdma_pkg;

   localparam int REG_W = 32;

   // register offsets
   localparam logic [1:0] OFS_CFG  = 2'd0;
   localparam logic [1:0] OFS_ADDR = 2'd1;
   localparam logic [1:0] OFS_IEN  = 2'd2;
   localparam logic [1:0] OFS_STAT = 2'd3;

   // settings bit positions
   localparam int CFG_RD  = 0;
   localparam int CFG_DEV = 1;
   localparam int CFG_MEM = 2;
   localparam int CFG_W   = 3;

   localparam int NUM_EVT = 3;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_DEV  = 2'd1,
      PH_MEM  = 2'd2
   } phase_e;

   // bit 0 device done, bit 1 memory done, bit 2 error
   typedef struct packed {
      logic err;
      logic mem_done;
      logic dev_done;
   } evt_t;

endpackage

// File: rtl/pgdma_buf.sv
module pgdma_buf #(
   parameter int WORDS = 128,
   parameter int LANES = 4,
   localparam int AW   = $clog2(WORDS)
) (
   input  logic               clk,
   input  logic [LANES-1:0]   we,
   input  logic [AW-1:0]      waddr,
   input  logic [8*LANES-1:0] wdata,
   input  logic [AW-1:0]      raddr,
   output logic [8*LANES-1:0] rdata
);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] store [WORDS];

      always_ff @(posedge clk) begin
         if (we[l]) store[waddr] <= wdata[8*l +: 8];
      end

      assign rdata[8*l +: 8] = store[raddr];
   end

endmodule

// File: rtl/pgdma_regs.sv
module pgdma_regs
   import pgdma_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  evt_t              evt,
   output logic              irq,
   output logic              start_rd,
   output logic              start_dev,
   output logic              start_mem,
   output logic              phase_clash,
   output logic              stop_req,
   output logic [ADDR_W-1:0] base_addr
);

   logic [CFG_W-1:0]   cfg_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [NUM_EVT-1:0] ien_q;
   logic [NUM_EVT-1:0] stat_q;
   logic [NUM_EVT-1:0] stat_d;
   logic [NUM_EVT-1:0] evt_bits;
   logic [REG_W-1:0]   addr_view;

   logic cfg_wr, addr_wr, ien_wr, stat_wr;
   logic new_dev, new_mem;

   assign cfg_wr  = reg_we && (reg_addr == OFS_CFG);
   assign addr_wr = reg_we && (reg_addr == OFS_ADDR);
   assign ien_wr  = reg_we && (reg_addr == OFS_IEN);
   assign stat_wr = reg_we && (reg_addr == OFS_STAT);

   assign new_dev = reg_wdata[CFG_DEV];
   assign new_mem = reg_wdata[CFG_MEM];

   // edge-triggered phase launch, decoded against the stored settings
   assign start_rd    = reg_wdata[CFG_RD];
   assign start_dev   = cfg_wr && new_dev && !new_mem && !cfg_q[CFG_DEV];
   assign start_mem   = cfg_wr && new_mem && !new_dev && !cfg_q[CFG_MEM];
   assign phase_clash = cfg_wr && new_dev && new_mem;
   assign stop_req    = cfg_wr && !new_dev && !new_mem;
   assign base_addr   = addr_q;

   assign evt_bits = evt;

   // status: a raised event wins over a simultaneous clear
   for (genvar b = 0; b < NUM_EVT; b++) begin : g_stat
      assign stat_d[b] = evt_bits[b] | (stat_q[b] & ~(stat_wr & reg_wdata[b]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         addr_q <= '0;
         ien_q  <= '0;
         stat_q <= '0;
      end else begin
         if (cfg_wr)  cfg_q  <= reg_wdata[CFG_W-1:0];
         if (addr_wr) addr_q <= reg_wdata[ADDR_W-1:0];
         if (ien_wr)  ien_q  <= reg_wdata[NUM_EVT-1:0];
         stat_q <= stat_d;
      end
   end

   if (ADDR_W == REG_W) begin : g_addr_full
      assign addr_view = addr_q;
   end else begin : g_addr_ext
      assign addr_view = {{(REG_W-ADDR_W){1'b0}}, addr_q};
   end

   always_comb begin
      unique case (reg_addr)
         OFS_CFG:  reg_rdata = {{(REG_W-CFG_W){1'b0}}, cfg_q};
         OFS_ADDR: reg_rdata = addr_view;
         OFS_IEN:  reg_rdata = {{(REG_W-NUM_EVT){1'b0}}, ien_q};
         default:  reg_rdata = {{(REG_W-NUM_EVT){1'b0}}, stat_q};
      endcase
   end

   assign irq = |(stat_q & ien_q);

endmodule

// File: rtl/pgdma_engine.sv
module pgdma_engine
   import pgdma_pkg::*;
#(
   parameter int PAGE_BYTES = 512,
   parameter int WORD_W     = 32,
   parameter int ADDR_W     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_rd,
   input  logic              start_dev,
   input  logic              start_mem,
   input  logic              phase_clash,
   input  logic              stop_req,
   input  logic [ADDR_W-1:0] base_addr,
   output evt_t              evt,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic              mem_err,
   input  logic              dev_in_valid,
   input  logic [7:0]        dev_in_data,
   output logic              dev_in_ready,
   output logic              dev_out_valid,
   output logic [7:0]        dev_out_data,
   input  logic              dev_out_ready
);

   localparam int BPW       = WORD_W / 8;
   localparam int LANE_W    = $clog2(BPW);
   localparam int WORDS     = PAGE_BYTES / BPW;
   localparam int IDX_W     = $clog2(PAGE_BYTES);
   localparam int WIDX_W    = IDX_W - LANE_W;
   localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(PAGE_BYTES - 1);
   localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(PAGE_BYTES - BPW);
   localparam logic [IDX_W-1:0] STEP_DEV  = IDX_W'(1);
   localparam logic [IDX_W-1:0] STEP_MEM  = IDX_W'(BPW);

   phase_e            phase_q;
   logic              dir_q;
   logic [ADDR_W-1:0] base_q;
   logic [IDX_W-1:0]  idx_q;

   logic busy, launch, any_start;
   logic dev_in_fire, dev_out_fire, dev_beat, mem_beat, mem_fail;
   logic beat, at_last;
   logic [IDX_W-1:0]  step;
   logic [LANE_W-1:0] lane;
   logic [WIDX_W-1:0] widx;
   logic [BPW-1:0]    buf_we;
   logic [WORD_W-1:0] buf_wd;
   logic [WORD_W-1:0] buf_rd;
   logic [7:0]        rd_bytes [BPW];

   assign busy      = (phase_q != PH_IDLE);
   assign any_start = start_dev | start_mem;
   assign launch    = any_start && !busy;

   assign lane = idx_q[LANE_W-1:0];
   assign widx = idx_q[IDX_W-1:LANE_W];

   // device side byte stream
   assign dev_in_ready  = (phase_q == PH_DEV) &&  dir_q;
   assign dev_out_valid = (phase_q == PH_DEV) && !dir_q;
   assign dev_in_fire   = dev_in_ready  && dev_in_valid;
   assign dev_out_fire  = dev_out_valid && dev_out_ready;
   assign dev_beat      = dev_in_fire | dev_out_fire;

   // memory side word interface
   assign mem_req   = (phase_q == PH_MEM);
   assign mem_we    = dir_q;
   assign mem_addr  = base_q + ADDR_W'(idx_q);
   assign mem_wdata = buf_rd;
   assign mem_beat  = mem_req && mem_ack && !mem_err;
   assign mem_fail  = mem_req && mem_ack &&  mem_err;

   assign beat    = dev_beat | mem_beat;
   assign step    = (phase_q == PH_DEV) ? STEP_DEV : STEP_MEM;
   assign at_last = (phase_q == PH_DEV) ? (idx_q == LAST_BYTE) : (idx_q == LAST_WORD);

   // phase completion and error events
   assign evt.dev_done = dev_beat && at_last && !stop_req;
   assign evt.mem_done = mem_beat && at_last && !stop_req;
   assign evt.err      = phase_clash || (any_start && busy) || (mem_fail && !stop_req);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         dir_q   <= 1'b0;
         base_q  <= '0;
         idx_q   <= '0;
      end else if (stop_req) begin
         phase_q <= PH_IDLE;
         idx_q   <= '0;
      end else if (launch) begin
         phase_q <= start_dev ? PH_DEV : PH_MEM;
         dir_q   <= start_rd;
         base_q  <= base_addr;
         idx_q   <= '0;
      end else if (mem_fail) begin
         phase_q <= PH_IDLE;
         idx_q   <= '0;
      end else if (beat) begin
         if (at_last) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
         end else begin
            idx_q <= idx_q + step;
         end
      end
   end

   // buffer write lanes: one lane per flash byte, all lanes per memory word
   for (genvar l = 0; l < BPW; l++) begin : g_wlane
      assign buf_we[l] = (dev_in_fire && (lane == LANE_W'(l))) || (mem_beat && !dir_q);
      assign buf_wd[8*l +: 8] = dir_q ? dev_in_data : mem_rdata[8*l +: 8];
      assign rd_bytes[l] = buf_rd[8*l +: 8];
   end

   assign dev_out_data = rd_bytes[lane];

   pgdma_buf #(
      .WORDS (WORDS),
      .LANES (BPW)
   ) u_buf (
      .clk   (clk),
      .we    (buf_we),
      .waddr (widx),
      .wdata (buf_wd),
      .raddr (widx),
      .rdata (buf_rd)
   );

endmodule

// File: rtl/pgdma_seq.sv
module pgdma_seq
   import pgdma_pkg::*;
#(
   parameter int PAGE_BYTES = 512,
   parameter int WORD_W     = 32,
   parameter int ADDR_W     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic              mem_err,
   input  logic              dev_in_valid,
   input  logic [7:0]        dev_in_data,
   output logic              dev_in_ready,
   output logic              dev_out_valid,
   output logic [7:0]        dev_out_data,
   input  logic              dev_out_ready
);

   localparam int BPW = WORD_W / 8;

   if ((WORD_W % 8) != 0 || WORD_W < 16 || (BPW & (BPW - 1)) != 0) begin : g_bad_word
      $error("WORD_W must be a power-of-two byte multiple of at least 16");
   end
   if (PAGE_BYTES < 2 * BPW || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two holding at least two words");
   end
   if (ADDR_W > REG_W || ADDR_W < $clog2(PAGE_BYTES)) begin : g_bad_addr
      $error("ADDR_W must fit the register width and span one page");
   end

   evt_t              evt;
   logic              start_rd, start_dev, start_mem, phase_clash, stop_req;
   logic [ADDR_W-1:0] base_addr;

   pgdma_regs #(
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_we      (reg_we),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .evt         (evt),
      .irq         (irq),
      .start_rd    (start_rd),
      .start_dev   (start_dev),
      .start_mem   (start_mem),
      .phase_clash (phase_clash),
      .stop_req    (stop_req),
      .base_addr   (base_addr)
   );

   pgdma_engine #(
      .PAGE_BYTES (PAGE_BYTES),
      .WORD_W     (WORD_W),
      .ADDR_W     (ADDR_W)
   ) u_engine (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_rd      (start_rd),
      .start_dev     (start_dev),
      .start_mem     (start_mem),
      .phase_clash   (phase_clash),
      .stop_req      (stop_req),
      .base_addr     (base_addr),
      .evt           (evt),
      .mem_req       (mem_req),
      .mem_we        (mem_we),
      .mem_addr      (mem_addr),
      .mem_wdata     (mem_wdata),
      .mem_ack       (mem_ack),
      .mem_rdata     (mem_rdata),
      .mem_err       (mem_err),
      .dev_in_valid  (dev_in_valid),
      .dev_in_data   (dev_in_data),
      .dev_in_ready  (dev_in_ready),
      .dev_out_valid (dev_out_valid),
      .dev_out_data  (dev_out_data),
      .dev_out_ready (dev_out_ready)
   );

endmodule

// File: rtl/pgdma_seq_chk.sv
module pgdma_seq_chk #(
   parameter int ADDR_W = 32
) (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_we,
   input logic [1:0]  reg_addr,
   input logic [31:0] reg_wdata,
   input logic [31:0] reg_rdata,
   input logic        irq,
   input logic        mem_req,
   input logic        mem_ack,
   input logic        mem_err,
   input logic        dev_in_ready,
   input logic        dev_out_valid
);

   logic quiet;
   assign quiet = !mem_req && !dev_in_ready && !dev_out_valid;

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R1: assert (quiet && !irq)
            else $error("outputs active during reset");
      end
   end

   assert_addr_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 2'd1) |=>
         (reg_addr != 2'd1 || reg_rdata[ADDR_W-1:0] == $past(reg_wdata[ADDR_W-1:0])));

   assert_stop_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 2'd0 && reg_wdata[2:1] == 2'b00) |=> quiet);

   assert_clash_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 2'd0 && reg_wdata[2:1] == 2'b11 && quiet) |=> quiet);

   assert_single_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req && (dev_in_ready || dev_out_valid)));

   assert_memerr_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && mem_err) |=> !mem_req);

   assert_irq_needs_status_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 2'd3 && reg_rdata[2:0] == 3'b000) |-> !irq);

   assert_irq_needs_enable_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 2'd2 && reg_rdata[2:0] == 3'b000) |-> !irq);

endmodule

bind pgdma_seq pgdma_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .reg_we        (reg_we),
   .reg_addr      (reg_addr),
   .reg_wdata     (reg_wdata),
   .reg_rdata     (reg_rdata),
   .irq           (irq),
   .mem_req       (mem_req),
   .mem_ack       (mem_ack),
   .mem_err       (mem_err),
   .dev_in_ready  (dev_in_ready),
   .dev_out_valid (dev_out_valid)
);

// File: tb/tb_pgdma_seq.sv
`timescale 1ns/1ps
module tb_pgdma_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        mem_err = 1'b0;
   logic        dev_in_valid = 1'b0;
   logic [7:0]  dev_in_data = '0;
   logic        dev_in_ready;
   logic        dev_out_valid;
   logic [7:0]  dev_out_data;
   logic        dev_out_ready = 1'b0;

   int checks = 0;
   int errors = 0;
   int k = 0;
   int out_count = 0;
   int wr_count = 0;
   bit acc = 0;
   bit err_inject = 0;
   logic [31:0] err_addr = '0;

   logic [31:0] mem_model [1024];
   logic [31:0] exp_maddr_q[$];
   logic [31:0] exp_mdata_q[$];
   logic [7:0]  exp_dev_q[$];

   always #2.5 clk = ~clk;

   pgdma_seq dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .mem_err(mem_err), .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
      .dev_in_ready(dev_in_ready), .dev_out_valid(dev_out_valid),
      .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready)
   );

   function automatic logic [7:0] pat(input int n);
      return 8'((n * 7) + 3);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic wait_stat(input int b, input string req);
      logic [31:0] v;
      for (int n = 0; n < 3000; n++) begin
         rd(2'd3, v);
         if (v[b]) return;
      end
      check(req, 32'd0, 32'd1);
   endtask

   // driver: expected memory writes of a read-direction page
   task automatic push_read_words(input logic [31:0] base, input int k0);
      for (int i = 0; i < 128; i++) begin
         exp_maddr_q.push_back(base + 32'(4 * i));
         exp_mdata_q.push_back({pat(k0+4*i+3), pat(k0+4*i+2), pat(k0+4*i+1), pat(k0+4*i)});
      end
   endtask

   // driver: preload memory and expect its bytes on the flash port
   task automatic push_write_bytes(input logic [31:0] base);
      for (int i = 0; i < 128; i++) begin
         logic [31:0] w;
         w = (32'(i) * 32'h0103_0507) ^ 32'hA5A5_0000;
         mem_model[base[11:2] + 10'(i)] = w;
         for (int j = 0; j < 4; j++) exp_dev_q.push_back(w[8*j +: 8]);
      end
   endtask

   // flash source
   initial begin
      int ph = 0;
      forever begin
         @(negedge clk);
         if (acc) k++;
         dev_in_valid = (ph % 4) != 3;
         dev_in_data  = pat(k);
         acc = dev_in_valid && dev_in_ready;
         ph++;
      end
   end

   // flash sink monitor
   initial begin
      int ph = 0;
      forever begin
         @(negedge clk);
         dev_out_ready = (ph % 3) != 2;
         if (dev_out_valid && dev_out_ready) begin
            out_count++;
            if (exp_dev_q.size() == 0) check("R5 unexpected byte", 32'(dev_out_data), 32'hFFFF_FFFF);
            else check("R5 byte", 32'(dev_out_data), 32'(exp_dev_q.pop_front()));
         end
         ph++;
      end
   end

   // memory responder and write monitor
   initial begin
      forever begin
         @(negedge clk);
         mem_ack   = mem_req;
         mem_err   = mem_req && err_inject && (mem_addr == err_addr);
         mem_rdata = mem_model[mem_addr[11:2]];
         if (mem_req && mem_we && !mem_err) begin
            wr_count++;
            if (exp_maddr_q.size() == 0) check("R4 unexpected write", mem_addr, 32'hFFFF_FFFF);
            else begin
               check("R4 address", mem_addr, exp_maddr_q.pop_front());
               check("R4 data", mem_wdata, exp_mdata_q.pop_front());
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int k0, kk;
      for (int i = 0; i < 1024; i++) mem_model[i] = '0;

      repeat (4) @(negedge clk);
      check("R1 irq in reset", 32'(irq), 32'd0);
      check("R1 quiet in reset", 32'({mem_req, dev_in_ready, dev_out_valid}), 32'd0);
      rst_n = 1'b1;
      rd(2'd3, v); check("R1 status", v, 32'd0);
      rd(2'd1, v); check("R1 address", v, 32'd0);
      check("R1 quiet", 32'({irq, mem_req, dev_in_ready, dev_out_valid}), 32'd0);

      // R2 address readback
      wr(2'd1, 32'h0000_0100);
      rd(2'd1, v); check("R2 readback", v, 32'h0000_0100);
      wr(2'd2, 32'd7);

      // R3 read direction, device phase
      k0 = k;
      push_read_words(32'h0000_0100, k0);
      wr(2'd0, 32'd3);
      wait_stat(0, "R3 device done");
      check("R3 byte count", 32'(k - k0), 32'd512);
      check("R3 ready falls", 32'(dev_in_ready), 32'd0);
      check("R12 irq on done", 32'(irq), 32'd1);

      // R6 rewriting a set phase bit starts nothing
      kk = k;
      wr(2'd0, 32'd3);
      @(negedge clk);
      check("R6 no restart", 32'(dev_in_ready), 32'd0);
      check("R6 no bytes", 32'(k - kk), 32'd0);

      // R11 clear
      wr(2'd3, 32'd1);
      rd(2'd3, v); check("R11 cleared", v, 32'd0);
      check("R12 irq low", 32'(irq), 32'd0);

      // R4 memory phase, clear of bit 1 in the same cycle as it is raised
      wr(2'd0, 32'd5);
      do @(negedge clk); while (!(mem_req && mem_addr == 32'h0000_02FC));
      reg_we = 1'b1; reg_addr = 2'd3; reg_wdata = 32'd2;
      @(negedge clk);
      reg_we = 1'b0;
      rd(2'd3, v); check("R11 set wins over clear", v, 32'd2);
      check("R4 all words", 32'(exp_maddr_q.size()), 32'd0);
      check("R4 write count", 32'(wr_count), 32'd128);
      wr(2'd3, 32'd0);
      rd(2'd3, v); check("R11 zero keeps", v, 32'd2);
      wr(2'd3, 32'd2);
      rd(2'd3, v); check("R11 clear bit 1", v, 32'd0);

      // R5 write direction: memory phase then device phase
      wr(2'd0, 32'd0);
      push_write_bytes(32'h0000_0400);
      wr(2'd1, 32'h0000_0400);
      wr(2'd0, 32'd4);
      wait_stat(1, "R5 memory done");
      wr(2'd3, 32'd2);
      wr(2'd0, 32'd2);
      wait_stat(0, "R5 device done");
      check("R5 all bytes", 32'(exp_dev_q.size()), 32'd0);
      check("R5 byte count", 32'(out_count), 32'd512);
      rd(2'd3, v); check("R5 status", v, 32'd1);
      wr(2'd3, 32'd7);

      // R9 start while busy
      wr(2'd0, 32'd0);
      wr(2'd0, 32'd3);
      repeat (20) @(negedge clk);
      wr(2'd0, 32'd5);
      rd(2'd3, v); check("R9 error raised", v, 32'd4);
      check("R9 no memory start", 32'(mem_req), 32'd0);
      wait_stat(0, "R9 running phase completes");
      rd(2'd3, v); check("R9 final status", v, 32'd5);
      wr(2'd3, 32'd7);

      // R8 both phase bits, R12 masking
      wr(2'd0, 32'd0);
      wr(2'd2, 32'd1);
      wr(2'd0, 32'd6);
      check("R8 nothing starts", 32'({mem_req, dev_in_ready, dev_out_valid}), 32'd0);
      rd(2'd3, v); check("R8 error", v, 32'd4);
      check("R12 masked", 32'(irq), 32'd0);
      wr(2'd2, 32'd4);
      @(negedge clk);
      check("R12 enabled", 32'(irq), 32'd1);
      wr(2'd3, 32'd7);
      wr(2'd2, 32'd7);

      // R7 stop
      wr(2'd0, 32'd0);
      wr(2'd0, 32'd3);
      repeat (30) @(negedge clk);
      wr(2'd0, 32'd0);
      check("R7 halted", 32'(dev_in_ready), 32'd0);
      repeat (700) @(negedge clk);
      rd(2'd3, v); check("R7 no done", v, 32'd0);
      check("R7 irq low", 32'(irq), 32'd0);

      // R10 memory error response
      wr(2'd1, 32'h0000_0800);
      err_addr = 32'h0000_0814;
      err_inject = 1'b1;
      wr(2'd0, 32'd4);
      wait_stat(2, "R10 error");
      check("R10 request dropped", 32'(mem_req), 32'd0);
      rd(2'd3, v); check("R10 no memory done", v, 32'd4);
      err_inject = 1'b0;

      check("R4 no stray writes", 32'(wr_count), 32'd128);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule